// File: doc/BRIEF.md
# Type 1 Configuration Forwarding Decoder

This block sits beside one port of a PCI-to-PCI bridge and classifies the address phase of each transaction it sees. It works out whether a Type 1 configuration access should cross the bridge unchanged, become a special cycle on the bus at the other side, or be dropped because it is itself a special cycle. In every other case it reports that the access is not claimed. The block only decides. Bus handshaking, Type 0 conversion, delayed-transaction queues and data movement are handled elsewhere.

The decoder takes the address/data word and the command nibble that are present while the address-phase strobe is high. It also takes a flag that gives the side the transaction arrived on, and the primary, secondary and subordinate bus number registers. The bus number is read from address bits 23:16, the device number from bits 15:11 and the function number from bits 10:8. The decision and two qualifiers are registered on the clock edge that samples the strobe, so the bridge control logic reads them one cycle later.

A transaction heading downstream must name a bus number strictly above the secondary number and no higher than the subordinate number. A transaction heading upstream must name a bus number outside the secondary-to-subordinate span, with both ends of that span counted as inside. Upstream forwarding and every special-cycle request also require a configuration write addressed to device 31, function 7.

Top module: `t1fwd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, fwd_code becomes 00 (not claimed) and fwd_delayed and fwd_single become 0.
- R2: Outputs are loaded on the rising edge where addr_phase is 1. After an edge where addr_phase is 0, fwd_code is 00 and both flags are 0, whatever the other inputs are.
- R3: From the primary side (from_secondary = 0), an access with ad[1:0] = 01 and cmd 1010 (config read) or 1011 (config write) gives fwd_code 01 (pass through) when sec_bus < ad[23:16] <= sub_bus.
- R4: From the primary side, a bus number equal to sec_bus, below sec_bus or above sub_bus never gives pass through.
- R5: From the secondary side, an access gives pass through (01) only if all of these hold: cmd is 1011, ad[1:0] is 01, ad[15:11] is 11111, ad[10:8] is 111, ad[23:16] lies outside sec_bus..sub_bus inclusive, and ad[23:16] differs from pri_bus.
- R6: From the secondary side, a config read, any other device or function number, or a bus number inside sec_bus..sub_bus inclusive gives 00.
- R7: From the primary side, a config write with ad[1:0] = 01, device 11111, function 111 and ad[23:16] equal to sec_bus gives fwd_code 10 (generate special cycle).
- R8: From the secondary side, the same write with ad[23:16] equal to pri_bus gives fwd_code 10. This takes priority over pass through.
- R9: Command 0001 (special cycle) gives fwd_code 11 (ignore) on either side, for any address.
- R10: fwd_delayed and fwd_single are both 1 only when fwd_code is 01 for a config write. They are 0 for a forwarded read, a special-cycle request, an ignore and an unclaimed access.
- R11: An address phase with ad[1:0] other than 01 and a command other than 0001 gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_phase | input | 1 | High during the address phase |
| ad | input | 32 | Address/data word sampled in the address phase |
| cmd | input | 4 | Bus command nibble |
| from_secondary | input | 1 | 1 when the transaction arrived on the secondary side (upstream) |
| pri_bus | input | 8 | Primary bus number register |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| fwd_code | output | 2 | 00 not claimed, 01 pass through, 10 special cycle, 11 ignore |
| fwd_delayed | output | 1 | Forwarded access is a delayed transaction |
| fwd_single | output | 1 | Forwarded access is limited to one data transfer |

## Verification
The assertions assume that the bus number registers are stable around each address phase and that sec_bus is no greater than sub_bus. They do not assume any ordering of pri_bus relative to that span. The stimulus programs the registers once, using primary 2, secondary 5 and subordinate 9, and then changes only the address word, the command, the side flag and the strobe. Each strobe pulse lasts one cycle, and idle cycles are placed between scenarios, so the return to the unclaimed state is checked on its own.

// File: rtl/t1fwd_pkg.sv
// Package: shared decision codes, command encodings and address field
// positions for the Type 1 configuration forwarding decoder.
package t1fwd_pkg;

    typedef enum logic [1:0] {
        FWD_NONE    = 2'b00,
        FWD_PASS    = 2'b01,
        FWD_SPECIAL = 2'b10,
        FWD_IGNORE  = 2'b11
    } fwd_dec_e;

    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int DEV_W   = 5;
    localparam int FN_LSB  = 8;
    localparam int FN_W    = 3;
    localparam logic [1:0] TYPE1_CODE = 2'b01;

endpackage

// File: rtl/t1fwd_fields.sv
// Module: t1fwd_fields
// Splits the address-phase word into bus number, type bits and device/function
// fields, and classifies the command nibble.
// Assumes: AD_W >= BUS_LSB + BUS_W.
module t1fwd_fields
    import t1fwd_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [3:0]       cmd,
    output logic [BUS_W-1:0] bus_num,
    output logic             is_type1,
    output logic             devfn_top,
    output logic             is_cfg_rd,
    output logic             is_cfg_wr,
    output logic             is_special
);

    localparam int BUS_MSB = BUS_LSB + BUS_W - 1;

    logic [DEV_W-1:0] dev_num;
    logic [FN_W-1:0]  fn_num;
    logic             unused_bits;

    // Field extraction from the address word.
    always_comb begin
        bus_num = ad[BUS_MSB:BUS_LSB];
        dev_num = ad[DEV_LSB +: DEV_W];
        fn_num  = ad[FN_LSB +: FN_W];
    end

    // Command and address classification.
    always_comb begin
        is_type1   = (ad[1:0] == TYPE1_CODE);
        devfn_top  = (&dev_num) && (&fn_num);
        is_cfg_rd  = (cmd == CMD_CFG_RD);
        is_cfg_wr  = (cmd == CMD_CFG_WR);
        is_special = (cmd == CMD_SPECIAL);
    end

    assign unused_bits = ^{ad[AD_W-1:BUS_MSB+1], ad[FN_LSB-1:2]};

endmodule

// File: rtl/t1fwd_range.sv
// Module: t1fwd_range
// Reports whether a bus number lies in the span lo..hi. The upper bound is
// always inclusive. LOWER_INCL selects an inclusive or exclusive lower bound.
// Assumes: lo and hi are stable register values.
module t1fwd_range #(
    parameter int BUS_W      = 8,
    parameter bit LOWER_INCL = 1'b1
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] lo,
    input  logic [BUS_W-1:0] hi,
    output logic             in_span
);

    logic above_lo;

    // Lower-bound comparison variant chosen by parameter.
    generate
        if (LOWER_INCL) begin : g_incl
            assign above_lo = (bus >= lo);
        end else begin : g_excl
            assign above_lo = (bus > lo);
        end
    endgenerate

    // Combine with inclusive upper bound.
    assign in_span = above_lo && (bus <= hi);

endmodule

// File: rtl/t1fwd_decide.sv
// Module: t1fwd_decide
// Priority decision: a special-cycle command is ignored; otherwise, for
// Type 1 addresses, special-cycle generation wins over pass-through.
// Assumes: inputs come from t1fwd_fields and t1fwd_range of the same phase.
module t1fwd_decide
    import t1fwd_pkg::*;
(
    input  logic     from_secondary,
    input  logic     is_type1,
    input  logic     devfn_top,
    input  logic     is_cfg_rd,
    input  logic     is_cfg_wr,
    input  logic     is_special,
    input  logic     in_down_span,
    input  logic     in_up_span,
    input  logic     bus_is_sec,
    input  logic     bus_is_pri,
    output fwd_dec_e decision,
    output logic     fwd_write
);

    // Priority-ordered decision for one address phase.
    always_comb begin
        decision  = FWD_NONE;
        fwd_write = 1'b0;
        if (is_special) begin
            decision = FWD_IGNORE;
        end else if (is_type1) begin
            if (!from_secondary) begin
                if (is_cfg_wr && devfn_top && bus_is_sec) begin
                    decision = FWD_SPECIAL;
                end else if ((is_cfg_rd || is_cfg_wr) && in_down_span) begin
                    decision  = FWD_PASS;
                    fwd_write = is_cfg_wr;
                end
            end else if (is_cfg_wr && devfn_top) begin
                if (bus_is_pri) begin
                    decision = FWD_SPECIAL;
                end else if (!in_up_span) begin
                    decision  = FWD_PASS;
                    fwd_write = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/t1fwd_decoder.sv
// Module: t1fwd_decoder (top)
// Classifies the address phase of a transaction at one bridge port and
// registers the forwarding decision and qualifiers one clock later.
// Assumes: sec_bus <= sub_bus; bus registers stable during address phases.
module t1fwd_decoder
    import t1fwd_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_phase,
    input  logic [AD_W-1:0]  ad,
    input  logic [3:0]       cmd,
    input  logic             from_secondary,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic [1:0]       fwd_code,
    output logic             fwd_delayed,
    output logic             fwd_single
);

    logic [BUS_W-1:0] bus_num;
    logic             is_type1, devfn_top, is_cfg_rd, is_cfg_wr, is_special;
    logic             in_down_span, in_up_span;
    logic             bus_is_sec, bus_is_pri;
    fwd_dec_e         decision;
    logic             fwd_write;

    t1fwd_fields #(.AD_W(AD_W), .BUS_W(BUS_W)) u_fields (
        .ad         (ad),
        .cmd        (cmd),
        .bus_num    (bus_num),
        .is_type1   (is_type1),
        .devfn_top  (devfn_top),
        .is_cfg_rd  (is_cfg_rd),
        .is_cfg_wr  (is_cfg_wr),
        .is_special (is_special)
    );

    t1fwd_range #(.BUS_W(BUS_W), .LOWER_INCL(1'b0)) u_down_span (
        .bus     (bus_num),
        .lo      (sec_bus),
        .hi      (sub_bus),
        .in_span (in_down_span)
    );

    t1fwd_range #(.BUS_W(BUS_W), .LOWER_INCL(1'b1)) u_up_span (
        .bus     (bus_num),
        .lo      (sec_bus),
        .hi      (sub_bus),
        .in_span (in_up_span)
    );

    // Equality tests against the far-side bus numbers.
    always_comb begin
        bus_is_sec = (bus_num == sec_bus);
        bus_is_pri = (bus_num == pri_bus);
    end

    t1fwd_decide u_decide (
        .from_secondary (from_secondary),
        .is_type1       (is_type1),
        .devfn_top      (devfn_top),
        .is_cfg_rd      (is_cfg_rd),
        .is_cfg_wr      (is_cfg_wr),
        .is_special     (is_special),
        .in_down_span   (in_down_span),
        .in_up_span     (in_up_span),
        .bus_is_sec     (bus_is_sec),
        .bus_is_pri     (bus_is_pri),
        .decision       (decision),
        .fwd_write      (fwd_write)
    );

    // Result register: loads on address phase, otherwise returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_code    <= FWD_NONE;
            fwd_delayed <= 1'b0;
            fwd_single  <= 1'b0;
        end else if (addr_phase) begin
            fwd_code    <= decision;
            fwd_delayed <= fwd_write;
            fwd_single  <= fwd_write;
        end else begin
            fwd_code    <= FWD_NONE;
            fwd_delayed <= 1'b0;
            fwd_single  <= 1'b0;
        end
    end

    // R2: no address phase means idle output on the next cycle.
    p_idle_without_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_phase |=> (fwd_code == FWD_NONE) && !fwd_delayed && !fwd_single);

    // R4: downstream bus at or below secondary never passes through.
    p_down_low_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase && !from_secondary && (ad[BUS_LSB +: BUS_W] <= sec_bus)
        |=> fwd_code != FWD_PASS);

    // R6: upstream non-write is never forwarded or converted.
    p_up_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase && from_secondary && (cmd != CMD_CFG_WR)
        |=> (fwd_code == FWD_NONE) || (fwd_code == FWD_IGNORE));

    // R9: special-cycle command is always ignored.
    p_special_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase && (cmd == CMD_SPECIAL) |=> fwd_code == FWD_IGNORE);

    // R10: qualifiers only accompany a pass-through decision.
    p_flags_with_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_delayed || fwd_single) |-> (fwd_code == FWD_PASS) && fwd_delayed && fwd_single);

    // R11: non-Type-1 address bits never claim.
    p_type_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase && (ad[1:0] != TYPE1_CODE) && (cmd != CMD_SPECIAL)
        |=> fwd_code == FWD_NONE);

endmodule

// File: tb/tb_t1fwd_decoder.sv
`timescale 1ns/1ps
module tb_t1fwd_decoder;

    localparam logic [1:0] C_NONE = 2'b00, C_PASS = 2'b01, C_SPC = 2'b10, C_IGN = 2'b11;
    localparam logic [3:0] RD = 4'b1010, WR = 4'b1011, SC = 4'b0001, MRD = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cmd = '0;
    logic        from_secondary = 1'b0;
    logic [7:0]  pri_bus = 8'd2, sec_bus = 8'd5, sub_bus = 8'd9;
    logic [1:0]  fwd_code;
    logic        fwd_delayed, fwd_single;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    t1fwd_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .ad(ad), .cmd(cmd),
        .from_secondary(from_secondary), .pri_bus(pri_bus), .sec_bus(sec_bus),
        .sub_bus(sub_bus), .fwd_code(fwd_code), .fwd_delayed(fwd_delayed),
        .fwd_single(fwd_single)
    );

    function automatic logic [31:0] mk_ad(input logic [7:0] bus, input logic [4:0] dev,
                                          input logic [2:0] fn, input logic [1:0] lo2);
        return {8'h00, bus, dev, fn, 6'b0, lo2};
    endfunction

    task automatic chk(input string req, input logic [1:0] ec, input logic ed, input logic es);
        tests++;
        if (fwd_code !== ec || fwd_delayed !== ed || fwd_single !== es) begin
            fails++;
            $display("FAIL %s: got code=%b dly=%b sgl=%b expected code=%b dly=%b sgl=%b",
                     req, fwd_code, fwd_delayed, fwd_single, ec, ed, es);
        end
    endtask

    // Drive one address phase, then sample after the edge that latched it.
    task automatic phase(input logic up, input logic [3:0] c, input logic [31:0] a,
                         input logic strobe);
        @(negedge clk);
        from_secondary = up; cmd = c; ad = a; addr_phase = strobe;
        @(negedge clk);
        addr_phase = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset state", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_down_pass;
        phase(1'b0, RD, mk_ad(8'd7, 5'd3, 3'd0, 2'b01), 1'b1);
        chk("R3 down read bus 7", C_PASS, 1'b0, 1'b0);
        phase(1'b0, WR, mk_ad(8'd9, 5'd1, 3'd2, 2'b01), 1'b1);
        chk("R3 down write bus 9 (upper inclusive)", C_PASS, 1'b1, 1'b1);
        phase(1'b0, WR, mk_ad(8'd6, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R3 down write bus 6", C_PASS, 1'b1, 1'b1);
    endtask

    task automatic t_down_bounds;
        phase(1'b0, RD, mk_ad(8'd5, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R4 down bus equals sec", C_NONE, 1'b0, 1'b0);
        phase(1'b0, RD, mk_ad(8'd10, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R4 down bus above sub", C_NONE, 1'b0, 1'b0);
        phase(1'b0, WR, mk_ad(8'd3, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R4 down bus below sec", C_NONE, 1'b0, 1'b0);
        phase(1'b0, MRD, mk_ad(8'd7, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R3 down memory read not claimed", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_special_down;
        phase(1'b0, WR, mk_ad(8'd5, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R7 down special at sec bus", C_SPC, 1'b0, 1'b0);
        phase(1'b0, WR, mk_ad(8'd5, 5'h1e, 3'h7, 2'b01), 1'b1);
        chk("R7 down special wrong device", C_NONE, 1'b0, 1'b0);
        phase(1'b0, RD, mk_ad(8'd5, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R7 down special needs write", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_up_pass;
        phase(1'b1, WR, mk_ad(8'd12, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R5 up write bus 12", C_PASS, 1'b1, 1'b1);
        phase(1'b1, WR, mk_ad(8'd4, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R5 up write bus 4", C_PASS, 1'b1, 1'b1);
    endtask

    task automatic t_up_reject;
        phase(1'b1, WR, mk_ad(8'd5, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R6 up bus equals sec", C_NONE, 1'b0, 1'b0);
        phase(1'b1, WR, mk_ad(8'd9, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R6 up bus equals sub", C_NONE, 1'b0, 1'b0);
        phase(1'b1, RD, mk_ad(8'd12, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R6 up read", C_NONE, 1'b0, 1'b0);
        phase(1'b1, WR, mk_ad(8'd12, 5'h1f, 3'h6, 2'b01), 1'b1);
        chk("R6 up wrong function", C_NONE, 1'b0, 1'b0);
        phase(1'b1, WR, mk_ad(8'd12, 5'h00, 3'h7, 2'b01), 1'b1);
        chk("R6 up wrong device", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_special_up;
        phase(1'b1, WR, mk_ad(8'd2, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R8 up special at primary bus", C_SPC, 1'b0, 1'b0);
    endtask

    task automatic t_ignore;
        phase(1'b0, SC, mk_ad(8'd7, 5'h1f, 3'h7, 2'b01), 1'b1);
        chk("R9 special cmd from primary", C_IGN, 1'b0, 1'b0);
        phase(1'b1, SC, mk_ad(8'd0, 5'h00, 3'h0, 2'b10), 1'b1);
        chk("R9 special cmd from secondary", C_IGN, 1'b0, 1'b0);
    endtask

    task automatic t_type_bits;
        phase(1'b0, RD, mk_ad(8'd7, 5'd0, 3'd0, 2'b00), 1'b1);
        chk("R11 ad[1:0]=00", C_NONE, 1'b0, 1'b0);
        phase(1'b0, WR, mk_ad(8'd7, 5'd0, 3'd0, 2'b11), 1'b1);
        chk("R11 ad[1:0]=11", C_NONE, 1'b0, 1'b0);
        phase(1'b1, WR, mk_ad(8'd12, 5'h1f, 3'h7, 2'b00), 1'b1);
        chk("R11 up ad[1:0]=00", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_no_strobe;
        phase(1'b0, WR, mk_ad(8'd7, 5'd0, 3'd0, 2'b01), 1'b1);
        chk("R10 write pass flags", C_PASS, 1'b1, 1'b1);
        phase(1'b0, WR, mk_ad(8'd7, 5'd0, 3'd0, 2'b01), 1'b0);
        chk("R2 no strobe returns idle", C_NONE, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 idle holds", C_NONE, 1'b0, 1'b0);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        from_secondary = 1'b0; cmd = WR; ad = mk_ad(8'd7, 5'd0, 3'd0, 2'b01);
        addr_phase = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset overrides address phase", C_NONE, 1'b0, 1'b0);
        addr_phase = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_down_pass();
        t_down_bounds();
        t_special_down();
        t_up_pass();
        t_up_reject();
        t_special_up();
        t_ignore();
        t_type_bits();
        t_no_strobe();
        t_mid_reset();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule